// File: doc/BRIEF.md
# Priority Vectored Interrupt Collector

This block collects a bank of interrupt request lines and turns them into one interrupt signal for a processor. Each source can be configured with a 2-bit priority, an enable, and a software-raise bit that acts like a hardware request. Among the sources that are enabled and pending, the block picks the winner and presents a word-aligned vector address. That address is a programmable base plus four times the winning source number.

The handler tells the collector that it has entered service in one of two ways. In normal mode it writes to the vector register. In read-side-effect mode the read that fetches the vector does it. In-service state is kept per priority level. A running handler can be preempted only by a strictly higher level, and a control bit can forbid any preemption. The handler ends by writing a one-hot level mask to the acknowledge register.

All registers sit on a simple single-cycle 32-bit register bus. There is no valid/ready handshake: every access completes in the cycle it is presented, and read data is combinational from the address. Address bits [3:2] choose how a write is applied.

Top module: `prio_intc`

## Requirements
- R1: The configuration word for source n is at byte offset 0x60 + 0x10*(n/4). Its 8-bit field occupies bits 8*(n%4)+7 down to 8*(n%4). Within a field, bits 1:0 are the priority, bit 2 is the enable and bit 3 is the software request. Field bits 7:4 always read as zero.
- R2: Address bits [3:2] select the write mode: 0 writes the value directly, 1 ORs the written ones in, 2 clears the written ones, and 3 inverts the written ones. A read at any of the four addresses returns the register value.
- R3: A source is pending when its enable is set and either its request line or its software bit is high. Offset 0x40 reads request lines 31:0 and offset 0x50 reads lines 63:32, unmasked. Writes to these offsets have no effect.
- R4: Among the eligible pending sources, the highest priority wins. When several share that priority, the lowest-numbered source wins.
- R5: Offset 0x00 reads as the base plus 4 times the winning source number. The base is at offset 0x160 and its bits 1:0 read as zero. If no eligible source is pending, offset 0x00 reads the value of the read/write scratch register at offset 0x170.
- R6: The irq output is high exactly when control bit 16 (control at offset 0x20) is set and an eligible pending source exists.
- R7: With control bit 18 clear, any write to offset 0x00 puts the winner's priority level in service, and irq falls in the next cycle unless a higher level is pending. A read of offset 0x00 changes nothing.
- R8: With control bit 18 set, a read of offset 0x00 puts the winner's level in service. A write to offset 0x00 changes nothing.
- R9: Offset 0x30 bits 5:0 give the number of the source most recently taken into service.
- R10: Writing ones to offset 0x10 clears in-service for the levels at those bit positions (bit k is level k). Lower pending levels can then raise irq again.
- R11: With control bit 19 clear, a pending source is eligible only if its priority is strictly above every level in service. With bit 19 set, no source is eligible while any level is in service.
- R12: After reset all registers read zero, no level is in service and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 64 | Hardware interrupt request lines |
| bus_addr | input | 7 | Word address, byte address bits [8:2] |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request to the processor |

## Verification
A corrupted in-service level shows up at irq in the same cycle it goes wrong. A level stuck set holds back a lower request that should preempt, and a level lost early re-raises irq right after the vector handshake. A wrong arbitration choice or a wrong base appears as a wrong vector on the next read of offset 0x00, and a wrong latched source number appears in the status word. The tests therefore pair every handshake with an irq sample one cycle later and with a vector or status read. Nesting, mode and acknowledge sequences are driven in the order where a stale level bit would change the observed result.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    ACC_PLAIN = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLR   = 2'd2,
    ACC_TOG   = 2'd3
  } acc_mode_e;

  localparam int CTRL_IRQ_EN_BIT = 16;
  localparam int CTRL_RSE_BIT    = 18;
  localparam int CTRL_NONEST_BIT = 19;

  localparam logic [31:0] CTRL_MASK  = (32'd1 << CTRL_IRQ_EN_BIT) |
                                       (32'd1 << CTRL_RSE_BIT) |
                                       (32'd1 << CTRL_NONEST_BIT);
  localparam logic [31:0] CFG_MASK   = 32'h0F0F_0F0F;
  localparam logic [31:0] VBASE_MASK = 32'hFFFF_FFFC;

  function automatic logic [31:0] apply_acc(input logic [31:0] cur,
                                            input logic [31:0] wd,
                                            input acc_mode_e   m);
    case (m)
      ACC_SET:  return cur | wd;
      ACC_CLR:  return cur & ~wd;
      ACC_TOG:  return cur ^ wd;
      default:  return wd;
    endcase
  endfunction

endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N_SRC  = 64,
  parameter int PRIO_W = 2,
  localparam int N_LVL = 1 << PRIO_W,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_SRC-1:0]               pend,
  input  logic [N_SRC-1:0][PRIO_W-1:0]   prio,
  input  logic [N_LVL-1:0]               lvl_ok,
  output logic                           win_vld,
  output logic [ID_W-1:0]                win_id,
  output logic [PRIO_W-1:0]              win_lvl
);

  logic [N_LVL-1:0] lv_hit;
  logic [ID_W-1:0]  lv_id [N_LVL];

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    logic            hit_g;
    logic [ID_W-1:0] id_g;
    always_comb begin
      hit_g = 1'b0;
      id_g  = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
        if (pend[i] && prio[i] == PRIO_W'(l)) begin
          hit_g = 1'b1;
          id_g  = ID_W'(i);
        end
      end
    end
    assign lv_hit[l] = hit_g && lvl_ok[l];
    assign lv_id[l]  = id_g;
  end

  always_comb begin
    win_vld = 1'b0;
    win_id  = '0;
    win_lvl = '0;
    for (int l = 0; l < N_LVL; l++) begin
      if (lv_hit[l]) begin
        win_vld = 1'b1;
        win_id  = lv_id[l];
        win_lvl = PRIO_W'(l);
      end
    end
  end

  // R4
  win_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> (pend[win_id] && prio[win_id] == win_lvl && lvl_ok[win_lvl]));

endmodule

// File: rtl/intc_level_track.sv
module intc_level_track #(
  parameter int PRIO_W = 2,
  localparam int N_LVL = 1 << PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              no_nest,
  input  logic              set_vld,
  input  logic [PRIO_W-1:0] set_lvl,
  input  logic [N_LVL-1:0]  ack_mask,
  output logic [N_LVL-1:0]  lvl_ok,
  output logic              any_isv
);

  logic [N_LVL-1:0]  isv;
  logic [PRIO_W-1:0] top_lvl;
  logic [N_LVL-1:0]  set_dec;

  assign set_dec = set_vld ? (N_LVL'(1) << set_lvl) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isv <= '0;
    else        isv <= (isv & ~ack_mask) | set_dec;
  end

  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < N_LVL; l++)
      if (isv[l]) top_lvl = PRIO_W'(l);
  end

  assign any_isv = |isv;

  for (genvar l = 0; l < N_LVL; l++) begin : g_ok
    assign lvl_ok[l] = no_nest ? !any_isv
                               : (!any_isv || PRIO_W'(l) > top_lvl);
  end

  // R7
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_vld |=> isv[$past(set_lvl)]);

  // R10
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mask[0] && !set_dec[0]) |=> !isv[0]);

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int PRIO_W = 2,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_req,
  input  logic [ADDR_W-1:2] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  localparam int N_LVL  = 1 << PRIO_W;
  localparam int ID_W   = $clog2(N_SRC);
  localparam int N_CFG  = N_SRC / 4;
  localparam int N_RAW  = N_SRC / 32;
  localparam int IDX_W  = ADDR_W - 4;
  localparam int CFG_IW = $clog2(N_CFG);
  localparam int RAW_IW = (N_RAW > 1) ? $clog2(N_RAW) : 1;

  localparam logic [IDX_W-1:0] I_VEC   = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_ACK   = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_CTRL  = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_STAT  = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_RAW0  = IDX_W'(4);
  localparam logic [IDX_W-1:0] I_CFG0  = IDX_W'(4 + N_RAW);
  localparam logic [IDX_W-1:0] I_VBASE = IDX_W'(4 + N_RAW + N_CFG);
  localparam logic [IDX_W-1:0] I_UNDEF = IDX_W'(5 + N_RAW + N_CFG);

  logic [IDX_W-1:0] idx;
  acc_mode_e        mode;
  logic [31:0]      ctrl_q, vbase_q, undef_q;
  logic [31:0]      cfg_q [N_CFG];
  logic [ID_W-1:0]  stat_id_q;

  assign idx  = bus_addr[ADDR_W-1:4];
  assign mode = acc_mode_e'(bus_addr[3:2]);

  logic [CFG_IW-1:0] cfg_sel;
  logic [RAW_IW-1:0] raw_sel;
  logic              in_cfg, in_raw;
  assign cfg_sel = CFG_IW'(idx - I_CFG0);
  assign raw_sel = RAW_IW'(idx - I_RAW0);
  assign in_cfg  = (idx >= I_CFG0) && (idx < I_VBASE);
  assign in_raw  = (idx >= I_RAW0) && (idx < I_CFG0);

  // per-source fields
  logic [N_SRC-1:0]             pend;
  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign prio[i] = cfg_q[i/4][8*(i%4) +: PRIO_W];
    assign pend[i] = cfg_q[i/4][8*(i%4) + 2] &
                     (src_req[i] | cfg_q[i/4][8*(i%4) + 3]);
  end

  logic [31:0] raw_w [N_RAW];
  for (genvar k = 0; k < N_RAW; k++) begin : g_raw
    assign raw_w[k] = src_req[32*k +: 32];
  end

  // arbitration and level tracking
  logic              win_vld;
  logic [ID_W-1:0]   win_id;
  logic [PRIO_W-1:0] win_lvl;
  logic [N_LVL-1:0]  lvl_ok;
  logic              any_isv;
  logic              take;
  logic [N_LVL-1:0]  ack_mask;

  intc_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend),
    .prio    (prio),
    .lvl_ok  (lvl_ok),
    .win_vld (win_vld),
    .win_id  (win_id),
    .win_lvl (win_lvl)
  );

  intc_level_track #(.PRIO_W(PRIO_W)) u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .no_nest  (ctrl_q[CTRL_NONEST_BIT]),
    .set_vld  (take),
    .set_lvl  (win_lvl),
    .ack_mask (ack_mask),
    .lvl_ok   (lvl_ok),
    .any_isv  (any_isv)
  );

  assign take = win_vld && (idx == I_VEC) &&
                (ctrl_q[CTRL_RSE_BIT] ? bus_rd : bus_wr);
  assign ack_mask = (bus_wr && idx == I_ACK) ? bus_wdata[N_LVL-1:0] : '0;

  assign irq = ctrl_q[CTRL_IRQ_EN_BIT] & win_vld;

  // vector
  logic [31:0] vec_val;
  assign vec_val = win_vld ? (vbase_q + {{(30-ID_W){1'b0}}, win_id, 2'b00})
                           : undef_q;

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      vbase_q   <= '0;
      undef_q   <= '0;
      stat_id_q <= '0;
      for (int c = 0; c < N_CFG; c++) cfg_q[c] <= '0;
    end else begin
      if (take) stat_id_q <= win_id;
      if (bus_wr) begin
        if (idx == I_CTRL)
          ctrl_q <= apply_acc(ctrl_q, bus_wdata, mode) & CTRL_MASK;
        else if (idx == I_VBASE)
          vbase_q <= apply_acc(vbase_q, bus_wdata, mode) & VBASE_MASK;
        else if (idx == I_UNDEF)
          undef_q <= apply_acc(undef_q, bus_wdata, mode);
        else if (in_cfg)
          cfg_q[cfg_sel] <= apply_acc(cfg_q[cfg_sel], bus_wdata, mode) & CFG_MASK;
      end
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (idx == I_VEC)        bus_rdata = vec_val;
    else if (idx == I_CTRL)  bus_rdata = ctrl_q;
    else if (idx == I_STAT)  bus_rdata = {{(32-ID_W){1'b0}}, stat_id_q};
    else if (in_raw)         bus_rdata = raw_w[raw_sel];
    else if (in_cfg)         bus_rdata = cfg_q[cfg_sel];
    else if (idx == I_VBASE) bus_rdata = vbase_q;
    else if (idx == I_UNDEF) bus_rdata = undef_q;
  end

  // R11
  no_nest_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTRL_NONEST_BIT] && any_isv) |-> !irq);

  // R7
  take_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !(win_vld && win_lvl <= $past(win_lvl)));

endmodule

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_req = '0;
  logic [8:2]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [31:0] VB = 32'h1000_0000;

  always #2.5 clk = ~clk;

  prio_intc i_prio_intc (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_req = '0; bus_wr = 0; bus_rd = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a[8:2]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a[8:2]; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] cfg_addr(int n);
    return 32'h60 + 32'h10 * (n / 4);
  endfunction

  task automatic set_cfg(int n, logic [7:0] f);
    int sh = 8 * (n % 4);
    wr(cfg_addr(n) + 8, 32'hFF << sh);
    wr(cfg_addr(n) + 4, {24'h0, f} << sh);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    #1 chk("R12 irq", {31'b0, irq}, 0);
    rd(32'h20, d); chk("R12 ctrl", d, 0);
    rd(32'h30, d); chk("R12 stat", d, 0);
    rd(32'h00, d); chk("R12 vector", d, 0);
    rd(32'h90, d); chk("R12 cfg", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    wr(32'h60, 32'hFFFF_FFFF); rd(32'h60, d); chk("R1 field mask", d, 32'h0F0F_0F0F);
    wr(32'h60, 32'h0);
    wr(32'h64, 32'h0000_0300); rd(32'h60, d); chk("R2 set alias", d, 32'h0000_0300);
    wr(32'h68, 32'h0000_0100); rd(32'h6C, d); chk("R2 clr alias", d, 32'h0000_0200);
    wr(32'h6C, 32'h0000_0201); rd(32'h64, d); chk("R2 tog alias", d, 32'h0000_0001);
    wr(32'h24, 32'h0001_0000); rd(32'h20, d); chk("R2 ctrl set", d, 32'h0001_0000);
    wr(32'h160, 32'h1234_5677); rd(32'h160, d); chk("R5 base low bits", d, 32'h1234_5674);
    wr(32'h170, 32'hDEAD_BEEF); rd(32'h170, d); chk("R5 scratch", d, 32'hDEAD_BEEF);
    src_req = 64'hA5A5_0F0F_1234_8001;
    wr(32'h40, 32'hFFFF_FFFF);
    rd(32'h40, d); chk("R3 raw low", d, 32'h1234_8001);
    rd(32'h50, d); chk("R3 raw high", d, 32'hA5A5_0F0F);
  endtask

  task automatic t_arb();
    logic [31:0] d;
    do_reset();
    wr(32'h160, VB);
    wr(32'h20, 32'h0001_0000);
    set_cfg(3, 8'h05); set_cfg(10, 8'h06); set_cfg(12, 8'h06);
    rd(cfg_addr(10), d); chk("R1 field place", d, 32'h0006_0000);
    src_req[3] = 1; src_req[10] = 1; src_req[12] = 1;
    #1 chk("R6 irq on", {31'b0, irq}, 1);
    rd(32'h00, d); chk("R4 tie lowest", d, VB + 40);
    set_cfg(20, 8'h0F);
    rd(32'h00, d); chk("R3 soft request", d, VB + 80);
    set_cfg(20, 8'h0B);
    rd(32'h00, d); chk("R3 enable masks soft", d, VB + 40);
    wr(32'h28, 32'h0001_0000);
    chk("R6 global off", {31'b0, irq}, 0);
  endtask

  task automatic t_nest();
    logic [31:0] d;
    do_reset();
    wr(32'h160, VB); wr(32'h170, 32'h55AA);
    wr(32'h20, 32'h0001_0000);
    set_cfg(3, 8'h05); set_cfg(10, 8'h06); set_cfg(20, 8'h07);
    src_req[10] = 1;
    #1 chk("R6 irq", {31'b0, irq}, 1);
    wr(32'h00, 32'h0);
    chk("R7 irq drops", {31'b0, irq}, 0);
    rd(32'h30, d); chk("R9 stat", d, 10);
    rd(32'h00, d); chk("R5 undef vector", d, 32'h55AA);
    src_req[3] = 1;
    #1 chk("R11 lower blocked", {31'b0, irq}, 0);
    src_req[20] = 1;
    #1 chk("R11 higher preempts", {31'b0, irq}, 1);
    rd(32'h00, d); chk("R5 vector", d, VB + 80);
    chk("R7 read no effect", {31'b0, irq}, 1);
    wr(32'h00, 32'h0);
    chk("R7 nested take", {31'b0, irq}, 0);
    rd(32'h30, d); chk("R9 stat nested", d, 20);
    src_req[20] = 0;
    wr(32'h10, 32'h8);
    chk("R10 level2 still held", {31'b0, irq}, 0);
    wr(32'h10, 32'h4);
    chk("R10 ack reopens", {31'b0, irq}, 1);
    rd(32'h00, d); chk("R10 vector after ack", d, VB + 40);
  endtask

  task automatic t_no_nest();
    logic [31:0] d;
    do_reset();
    wr(32'h160, VB);
    wr(32'h20, 32'h0009_0000);
    set_cfg(10, 8'h06); set_cfg(20, 8'h07);
    src_req[10] = 1;
    wr(32'h00, 32'h0);
    src_req[20] = 1;
    #1 chk("R11 no nesting", {31'b0, irq}, 0);
    wr(32'h10, 32'h4);
    chk("R11 after ack", {31'b0, irq}, 1);
    rd(32'h00, d); chk("R4 highest wins", d, VB + 80);
  endtask

  task automatic t_rse();
    logic [31:0] d;
    do_reset();
    wr(32'h160, VB);
    wr(32'h20, 32'h0005_0000);
    set_cfg(10, 8'h06);
    src_req[10] = 1;
    wr(32'h00, 32'h0);
    chk("R8 write ignored", {31'b0, irq}, 1);
    rd(32'h00, d); chk("R8 vector", d, VB + 40);
    chk("R8 read takes", {31'b0, irq}, 0);
    rd(32'h30, d); chk("R9 stat rse", d, 10);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_arb();
    t_nest();
    t_no_nest();
    t_rse();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule